// File: doc/BRIEF.md
# Two-Wire Configuration Register Slave

This block is the serial configuration port of a clock generator. It watches the two open-drain bus lines, SCL and SDA, by sampling them with a fast system clock. Each line passes through a synchronizer and a glitch filter. From the cleaned lines the block finds start conditions, stop conditions and clock edges. It keeps six 8-bit configuration bytes and presents them to the rest of the chip as a flat parallel bus. It also decodes the control fields of byte 0 into separate control outputs.

Transfers are whole-bank only, and there is no register pointer. A write to address byte 0xD2 carries two header bytes, which are acknowledged and then thrown away. The data bytes that follow fill byte 0 upward. A read from address byte 0xD3 returns a count byte, then the six bytes in order.

The frequency-select strap pins are captured while reset is held. They come back inverted in the low nibble of byte 4, and that nibble is read-only. When byte 0 does not select its own frequency code, the captured strap levels drive the frequency-select output.

Top module: `cfg_serial_slave`

## Requirements
- R1: While and after reset, `sda_pull_low` is 0. Byte 0 resets to 0x00, and bytes 1, 2, 3 and 5 reset to 0xFF. Byte 4 resets to 0xF in bits 7:4, and its bits 3:0 read as the inverted captured straps.
- R2: The address byte is checked against the 7-bit address 0x69. The block acknowledges only 0xD2, which is a write, and 0xD3, which is a read. For any other address it leaves SDA released and changes no register.
- R3: On a write, the first two bytes after the address are acknowledged, and neither of them changes any register.
- R4: Write data bytes after the header are stored in order into bytes 0, 1, 2 and so on, and each one is acknowledged by pulling SDA low for the ninth clock.
- R5: A stop after any complete data byte ends the write. Bytes already written keep their new values, and the rest keep their old values.
- R6: A read returns the count byte 0x06 first, then bytes 0 through 5. Each byte is sent MSB first. The next byte follows only when the master acknowledges.
- R7: Data bytes after the sixth are acknowledged and discarded.
- R8: The strap pins are captured only while `rst_n` is low. Byte 4 bits 3:0 read as the bitwise inverse of the captured value. Later pin changes and writes to those bits have no effect.
- R9: After the master does not acknowledge a read byte, the block releases SDA and holds it released until the next start. A new start is then served normally.
- R10: A pulse on SDA or SCL shorter than `FILT_LEN` system clocks is ignored, so a one-cycle SDA pulse while SCL is high neither starts nor stops a transfer.
- R11: Byte 0 decodes as follows:
  - `out_tristate` is bit 0.
  - `spread_on` is bit 1.
  - `spread_down` is bit 7, where 1 means down spread and 0 means center spread.
  - When bit 3 is 1, `freq_sel` is {bit 2, bits 6:4}. When bit 3 is 0, `freq_sel` is the captured strap pin levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Synchronous active-low reset; straps captured while low |
| scl_in | input | 1 | Serial clock line level |
| sda_in | input | 1 | Serial data line level (wired-AND of all drivers) |
| sda_pull_low | output | 1 | 1 pulls SDA low (open-drain) |
| strap_pins | input | 4 | Frequency-select strap levels |
| cfg_bytes | output | 48 | Configuration bytes, byte k at bits 8k+7:8k |
| out_tristate | output | 1 | Byte 0 bit 0 |
| spread_on | output | 1 | Byte 0 bit 1 |
| spread_down | output | 1 | Byte 0 bit 7 |
| freq_sel | output | 4 | Effective frequency-select code |

## Verification
The glitch filter and the start/stop detector both act on SDA while SCL is high. A one-cycle SDA pulse lands in exactly the window where a real start or stop would be detected. The bench inserts such a pulse in the middle of a data bit of a write. It then judges the result at the ports: every byte of the write must still be acknowledged, and the byte must appear intact in the configuration outputs and on a later read. Randomized write lengths, including zero and more than six data bytes, each followed by a full read, check the commit-on-stop path against a bench model.

// File: rtl/cfg_serial_pkg.sv
// Shared types and constants for the two-wire configuration slave.
package cfg_serial_pkg;
    localparam int          STRAP_W  = 4;
    localparam logic [6:0]  DEV_ADDR = 7'h69;   // 0xD2 write / 0xD3 read

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_RX,
        PH_ACK,
        PH_TX,
        PH_MACK
    } phase_t;
endpackage

// File: rtl/line_filter.sv
// Two-flop synchronizer followed by a persistence filter.
// The clean output takes a new level only after the synchronized input has
// differed from it for FILT_LEN consecutive clocks.
// Assumes: FILT_LEN >= 2; idle line level is high.
module line_filter #(
    parameter int FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic clean
);
    localparam int CW = $clog2(FILT_LEN + 1);

    logic          s1, s2;
    logic [CW-1:0] run_cnt;

    // synchronize and filter the line
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1      <= 1'b1;
            s2      <= 1'b1;
            clean   <= 1'b1;
            run_cnt <= '0;
        end else begin
            s1 <= raw;
            s2 <= s1;
            if (s2 == clean) begin
                run_cnt <= '0;
            end else if (run_cnt == CW'(FILT_LEN - 1)) begin
                clean   <= s2;
                run_cnt <= '0;
            end else begin
                run_cnt <= run_cnt + 1'b1;
            end
        end
    end

    // R10
    filt_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(clean) |-> (clean == $past(s2)));
endmodule

// File: rtl/bus_cond.sv
// Detects bus conditions on the filtered lines: SCL rise/fall, start
// (SDA falls with SCL high) and stop (SDA rises with SCL high).
// Assumes inputs are already synchronous to clk.
module bus_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_c,
    input  logic sda_c,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    logic scl_p, sda_p;

    // remember previous line levels
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_c;
            sda_p <= sda_c;
        end
    end

    assign scl_rise = scl_c & ~scl_p;
    assign scl_fall = ~scl_c & scl_p;
    assign start_ev = scl_c & scl_p & sda_p & ~sda_c;
    assign stop_ev  = scl_c & scl_p & ~sda_p & sda_c;
endmodule

// File: rtl/cfg_regfile.sv
// Configuration byte storage with strap capture.
// Straps are sampled every clock while rst_n is low and frozen afterwards.
// Byte STRAP_REG carries the inverted straps in its low bits (read-only).
// Assumes NUM_REGS >= 2.
module cfg_regfile
    import cfg_serial_pkg::*;
#(
    parameter int NUM_REGS = 6,
    parameter int IW       = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we,
    input  logic [IW-1:0]         widx,
    input  logic [7:0]            wdata,
    input  logic [STRAP_W-1:0]    strap_pins,
    output logic [8*NUM_REGS-1:0] flat,
    output logic [STRAP_W-1:0]    strap_lat
);
    localparam int STRAP_REG = NUM_REGS - 2;

    logic [7:0] store [NUM_REGS];

    // reset defaults, strap capture and the single write port
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++)
                store[i] <= (i == 0) ? 8'h00 : 8'hFF;
            strap_lat <= strap_pins;
        end else if (we && (int'(widx) < NUM_REGS)) begin
            store[widx] <= wdata;
        end
    end

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_view
        if (g == STRAP_REG) begin : g_strap
            assign flat[8*g +: 8] = {store[g][7:STRAP_W], ~strap_lat};
        end else begin : g_plain
            assign flat[8*g +: 8] = store[g];
        end
    end

    // R8
    strap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(strap_lat));

    // R4
    write_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(we) && (int'($past(widx)) < NUM_REGS)) |-> (store[$past(widx)] == $past(wdata)));
endmodule

// File: rtl/cfg_serial_slave.sv
// Two-wire configuration slave for a clock generator.
// Write: address 0xD2, two ignored header bytes, then data into byte 0 up.
// Read: address 0xD3, count byte, then bytes 0..NUM_REGS-1.
// Assumes the bus clock is much slower than clk (>= 4*(FILT_LEN+3) clocks
// per SCL phase). No clock stretching.
module cfg_serial_slave
    import cfg_serial_pkg::*;
#(
    parameter int NUM_REGS = 6,
    parameter int FILT_LEN = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_in,
    input  logic                  sda_in,
    output logic                  sda_pull_low,
    input  logic [STRAP_W-1:0]    strap_pins,
    output logic [8*NUM_REGS-1:0] cfg_bytes,
    output logic                  out_tristate,
    output logic                  spread_on,
    output logic                  spread_down,
    output logic [3:0]            freq_sel
);
    localparam int PW      = $clog2(NUM_REGS + 2);
    localparam int RD_LAST = NUM_REGS + 1;

    logic [1:0] raw_lines, clean_lines;
    logic       scl_c, sda_c;
    logic       scl_rise, scl_fall, start_ev, stop_ev;

    assign raw_lines = {scl_in, sda_in};

    for (genvar g = 0; g < 2; g++) begin : g_line
        line_filter #(.FILT_LEN(FILT_LEN)) u_filt (
            .clk   (clk),
            .rst_n (rst_n),
            .raw   (raw_lines[g]),
            .clean (clean_lines[g])
        );
    end

    assign scl_c = clean_lines[1];
    assign sda_c = clean_lines[0];

    bus_cond u_cond (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_c    (scl_c),
        .sda_c    (sda_c),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev)
    );

    phase_t          phase;
    logic [3:0]      bitcnt;
    logic [7:0]      rx_sr, tx_sr, tx_sel;
    logic            rd_mode, is_addr, mack_ok, sda_oe;
    logic [1:0]      hdr_cnt;
    logic [PW-1:0]   wr_ptr, rd_ptr, rd_next;
    logic            reg_we;
    logic [PW-1:0]   reg_idx;
    logic [7:0]      reg_wd;
    logic [STRAP_W-1:0] strap_lat;

    cfg_regfile #(.NUM_REGS(NUM_REGS), .IW(PW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .we         (reg_we),
        .widx       (reg_idx),
        .wdata      (reg_wd),
        .strap_pins (strap_pins),
        .flat       (cfg_bytes),
        .strap_lat  (strap_lat)
    );

    // pick the next byte to transmit: count, bank bytes, then idle ones
    always_comb begin
        if (rd_ptr == '0)
            tx_sel = 8'(NUM_REGS);
        else if (int'(rd_ptr) <= NUM_REGS)
            tx_sel = cfg_bytes[8*(int'(rd_ptr) - 1) +: 8];
        else
            tx_sel = 8'hFF;
    end

    assign rd_next = (rd_ptr == PW'(RD_LAST)) ? rd_ptr : rd_ptr + 1'b1;

    // protocol sequencer: address, header, data, acknowledge, readback
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_IDLE;
            bitcnt  <= '0;
            rx_sr   <= '0;
            tx_sr   <= '0;
            rd_mode <= 1'b0;
            is_addr <= 1'b0;
            mack_ok <= 1'b0;
            sda_oe  <= 1'b0;
            hdr_cnt <= '0;
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            reg_we  <= 1'b0;
            reg_idx <= '0;
            reg_wd  <= '0;
        end else begin
            reg_we <= 1'b0;
            if (start_ev) begin
                phase   <= PH_RX;
                bitcnt  <= '0;
                is_addr <= 1'b1;
                sda_oe  <= 1'b0;
                hdr_cnt <= '0;
                wr_ptr  <= '0;
                rd_ptr  <= '0;
            end else if (stop_ev) begin
                phase  <= PH_IDLE;
                sda_oe <= 1'b0;
            end else begin
                case (phase)
                    PH_RX: begin
                        if (scl_rise) begin
                            rx_sr  <= {rx_sr[6:0], sda_c};
                            bitcnt <= bitcnt + 1'b1;
                        end else if (scl_fall && bitcnt == 4'd8) begin
                            bitcnt <= '0;
                            if (is_addr) begin
                                is_addr <= 1'b0;
                                if (rx_sr[7:1] == DEV_ADDR) begin
                                    rd_mode <= rx_sr[0];
                                    phase   <= PH_ACK;
                                    sda_oe  <= 1'b1;
                                end else begin
                                    phase <= PH_IDLE;
                                end
                            end else begin
                                phase  <= PH_ACK;
                                sda_oe <= 1'b1;
                                if (hdr_cnt != 2'd2) begin
                                    hdr_cnt <= hdr_cnt + 1'b1;
                                end else if (int'(wr_ptr) < NUM_REGS) begin
                                    reg_we  <= 1'b1;
                                    reg_idx <= wr_ptr;
                                    reg_wd  <= rx_sr;
                                    wr_ptr  <= wr_ptr + 1'b1;
                                end
                            end
                        end
                    end
                    PH_ACK: begin
                        if (scl_fall) begin
                            if (rd_mode) begin
                                tx_sr  <= {tx_sel[6:0], 1'b0};
                                sda_oe <= ~tx_sel[7];
                                bitcnt <= 4'd1;
                                rd_ptr <= rd_next;
                                phase  <= PH_TX;
                            end else begin
                                sda_oe <= 1'b0;
                                phase  <= PH_RX;
                            end
                        end
                    end
                    PH_TX: begin
                        if (scl_fall) begin
                            if (bitcnt == 4'd8) begin
                                sda_oe <= 1'b0;
                                bitcnt <= '0;
                                phase  <= PH_MACK;
                            end else begin
                                sda_oe <= ~tx_sr[7];
                                tx_sr  <= {tx_sr[6:0], 1'b0};
                                bitcnt <= bitcnt + 1'b1;
                            end
                        end
                    end
                    PH_MACK: begin
                        if (scl_rise) begin
                            mack_ok <= ~sda_c;
                        end else if (scl_fall) begin
                            if (mack_ok) begin
                                tx_sr  <= {tx_sel[6:0], 1'b0};
                                sda_oe <= ~tx_sel[7];
                                bitcnt <= 4'd1;
                                rd_ptr <= rd_next;
                                phase  <= PH_TX;
                            end else begin
                                phase <= PH_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign sda_pull_low = sda_oe;

    // decode the control fields of byte 0
    always_comb begin
        out_tristate = cfg_bytes[0];
        spread_on    = cfg_bytes[1];
        spread_down  = cfg_bytes[7];
        freq_sel     = cfg_bytes[3] ? {cfg_bytes[2], cfg_bytes[6:4]} : strap_lat;
    end

    // R9
    idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE) |-> !sda_oe);

    // R4
    rx_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_RX) |-> !sda_oe);

    // R5
    stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_ev && !start_ev) |=> (phase == PH_IDLE));

    // R7
    wr_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(wr_ptr) <= NUM_REGS);
endmodule

// File: tb/sim_cfg_serial_slave.sv
module sim_cfg_serial_slave;
    localparam int N = 6;
    localparam int Q = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic sda_line;
    logic sda_pull_low;
    logic [3:0] strap_pins = 4'b1010;
    logic [8*N-1:0] cfg_bytes;
    logic out_tristate, spread_on, spread_down;
    logic [3:0] freq_sel;

    int n_chk = 0, n_err = 0;
    bit done = 1'b0;

    logic [7:0] m [N];
    logic [3:0] strap_cap;
    logic [7:0] rbuf [8];
    logic [7:0] wbuf [10];

    assign sda_line = sda_m & ~sda_pull_low;

    always #2 clk = ~clk;

    cfg_serial_slave #(.NUM_REGS(N), .FILT_LEN(3)) u0 (
        .clk, .rst_n, .scl_in(scl_m), .sda_in(sda_line), .sda_pull_low,
        .strap_pins, .cfg_bytes, .out_tristate, .spread_on, .spread_down, .freq_sel
    );

    function automatic logic [7:0] exp_byte(int i);
        return (i == 4) ? {m[4][7:4], ~strap_cap} : m[i];
    endfunction

    function automatic logic [8*N-1:0] exp_flat();
        logic [8*N-1:0] f;
        for (int i = 0; i < N; i++) f[8*i +: 8] = exp_byte(i);
        return f;
    endfunction

    task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic wr_byte(logic [7:0] b, bit glitch, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; tick(Q);
            scl_m = 1'b1; tick(Q);
            if (glitch && i == 3) begin
                sda_m = ~b[i]; tick(1);
                sda_m = b[i];  tick(Q - 1);
            end else begin
                tick(Q);
            end
            scl_m = 1'b0; tick(Q);
        end
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        ack = ~sda_line;
        tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic rd_byte(bit give_ack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 0; i < 8; i++) begin
            tick(Q);
            scl_m = 1'b1; tick(Q);
            b = {b[6:0], sda_line};
            tick(Q);
            scl_m = 1'b0;
        end
        tick(Q);
        sda_m = ~give_ack; tick(Q);
        scl_m = 1'b1; tick(2*Q);
        scl_m = 1'b0; tick(Q);
        sda_m = 1'b1;
    endtask

    // write: address, two header bytes, n data bytes from wbuf, stop
    task automatic do_write(int n, bit glitch_first, string tag);
        bit a;
        bus_start();
        wr_byte(8'hD2, 1'b0, a);
        check(a, {tag, " R2 write address ack"}, a, 1);
        for (int h = 0; h < 2; h++) begin
            wr_byte(8'($urandom), 1'b0, a);
            check(a, {tag, " R3 header ack"}, a, 1);
        end
        for (int i = 0; i < n; i++) begin
            wr_byte(wbuf[i], glitch_first && i == 0, a);
            check(a, {tag, (i >= N) ? " R7 extra data ack" : " R4 data ack"}, a, 1);
            if (i < N) m[i] = wbuf[i];
        end
        bus_stop();
        tick(4);
    endtask

    // full read of count + all bytes, compared with the model
    task automatic do_read_all(string tag);
        bit a;
        logic [7:0] b;
        bus_start();
        wr_byte(8'hD3, 1'b0, a);
        check(a, {tag, " R2 read address ack"}, a, 1);
        for (int i = 0; i <= N; i++) begin
            rd_byte(i < N, b);
            rbuf[i] = b;
        end
        bus_stop();
        check(rbuf[0] == 8'(N), {tag, " R6 count byte"}, rbuf[0], N);
        for (int i = 0; i < N; i++)
            check(rbuf[i+1] === exp_byte(i), {tag, (i == 4) ? " R8 strap byte" : " R6 read byte"},
                  rbuf[i+1], exp_byte(i));
        check(cfg_bytes === exp_flat(), {tag, " R5 parallel bytes"}, cfg_bytes, exp_flat());
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        bit a;
        logic [7:0] b;
        void'($urandom(32'd4242));
        m[0] = 8'h00;
        for (int i = 1; i < N; i++) m[i] = 8'hFF;
        strap_cap = 4'b1010;
        tick(6);
        check(sda_pull_low == 1'b0, "R1 SDA released in reset", sda_pull_low, 0);
        rst_n = 1'b1;
        tick(2);
        strap_pins = 4'b0101;   // R8: later pin change must not matter
        tick(4);
        check(sda_pull_low == 1'b0, "R1 SDA released after reset", sda_pull_low, 0);
        check(cfg_bytes === exp_flat(), "R1 default bytes", cfg_bytes, exp_flat());
        check(freq_sel == 4'b1010, "R11 R8 freq from captured straps", freq_sel, 4'b1010);
        check({out_tristate, spread_on, spread_down} == 3'b000, "R11 default controls",
              {out_tristate, spread_on, spread_down}, 0);

        do_read_all("reset readback");

        // R2: foreign address is not acknowledged and changes nothing
        bus_start();
        wr_byte(8'hA4, 1'b0, a);
        check(!a, "R2 foreign address nack", a, 0);
        wr_byte(8'h55, 1'b0, a);
        check(!a, "R2 foreign data nack", a, 0);
        bus_stop();
        check(cfg_bytes === exp_flat(), "R2 bank unchanged", cfg_bytes, exp_flat());

        // R3 R4 R5: short write, stop after three bytes
        wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
        do_write(3, 1'b0, "short");
        do_read_all("short");

        // R7 R8: long write, writes into strap nibble ignored
        for (int i = 0; i < 9; i++) wbuf[i] = 8'h40 + 8'(i * 17);
        do_write(9, 1'b0, "long");
        do_read_all("long");

        // R11: byte 0 decode
        wbuf[0] = 8'hBA;
        do_write(1, 1'b0, "decode");
        check(freq_sel == 4'b0011, "R11 freq from byte 0", freq_sel, 4'b0011);
        check({spread_down, spread_on, out_tristate} == 3'b110, "R11 spread fields",
              {spread_down, spread_on, out_tristate}, 3'b110);
        wbuf[0] = 8'h01;
        do_write(1, 1'b0, "decode2");
        check(out_tristate == 1'b1, "R11 tristate bit", out_tristate, 1);
        check(freq_sel == 4'b1010, "R11 R8 freq back to straps", freq_sel, 4'b1010);

        // R9: master nack, then bus clocks must see SDA released
        bus_start();
        wr_byte(8'hD3, 1'b0, a);
        rd_byte(1'b0, b);
        check(b == 8'(N), "R9 count before nack", b, N);
        for (int i = 0; i < 9; i++) begin
            tick(Q); scl_m = 1'b1; tick(Q);
            check(sda_line == 1'b1, "R9 SDA released after nack", sda_line, 1);
            tick(Q); scl_m = 1'b0; tick(Q);
        end
        do_read_all("after nack");

        // R10: one-cycle SDA pulse during SCL high inside a data byte
        wbuf[0] = 8'h5C; wbuf[1] = 8'hA3;
        do_write(2, 1'b1, "glitch R10");
        check(cfg_bytes[7:0] == 8'h5C, "R10 byte survives pulse", cfg_bytes[7:0], 8'h5C);
        do_read_all("glitch R10");

        // random write lengths, header values and data
        for (int it = 0; it < 10; it++) begin
            int n;
            n = $urandom_range(0, 8);
            for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
            do_write(n, 1'b0, "random");
            do_read_all("random");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule